// File: doc/BRIEF.md
# Serial Result Shifter with Tag Chaining

This block is the digital output port of a serial converter that runs on a data clock supplied from outside. Each conversion produces a 16-bit result, which arrives on a parallel bus with a valid strobe. The block holds that result until a read frame begins. A frame begins when the read/convert control returns high while chip select is low. The block first drives a one-clock sync pulse. It then shifts the held word out on a single data line, most significant bit first.

Once the local word has been sent, the data line stops carrying local bits. It carries a delayed copy of the tag input instead, one bit per clock. The delay is fixed. Several devices can therefore share the clock, the chip select and the read/convert line, with each device's tag input fed from the data line of the next device. A receiver then reads all the words in sequence from the first device's data line. The receiver samples each bit on the falling clock edge of the cycle in which that bit was driven.

Top module: `ser_out_shifter`

## Requirements
Rising edges are numbered from the start of a frame. Edge 1 is the first rising edge at which read/convert is sampled high after a low sample while chip select is low. "After edge k" means the output value between rising edges k and k+1.

- R1: After reset, sync_o, data_o and frame_o are 0. Read/convert being high at reset does not start a frame; it must first be sampled low.
- R2: sync_o is 1 after edge 1 only. It is 0 after edge 2.
- R3: After edges 2 to 17, data_o carries the held word. Bit 15 (the MSB) comes after edge 2 and bit 0 (the LSB) comes after edge 17.
- R4: frame_o is 1 from edge 1 through edge 17, which is WIDTH+1 clocks. It is 0 after edge 18.
- R5: After any edge k of 18 or later, data_o equals the tag_i value sampled at rising edge k-15. tag_i is registered on every rising edge.
- R6: Take two instances sharing the clock, chip select and read/convert, with the upstream tag_i tied to the downstream data_o. The upstream data_o after edges 2 to 33 is the 32-bit concatenation of the upstream word followed by the downstream word.
- R7: result_valid_i stores result_i on any rising edge. A frame sends the value held before its edge 1. A strobe during a frame does not change the word being sent; that value goes out in the next frame.
- R8: While chip select is high, sync_o, data_o and frame_o become 0 on the next edge and any frame is cancelled. A rise of read/convert seen while chip select is high starts no frame.
- R9: If read/convert is sampled high after a low sample during a frame, the frame restarts. A new sync pulse follows, and then the currently held word is sent from its MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | External data clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| rc_i | input | 1 | Read/convert control; a rise with chip select low starts a frame |
| tag_i | input | 1 | Serial input from the downstream device in a chain |
| result_i | input | WIDTH | Parallel conversion result |
| result_valid_i | input | 1 | Stores result_i for the next frame |
| sync_o | output | 1 | One-clock pulse that marks the start of a frame |
| data_o | output | 1 | Serial data: local word, then the delayed tag stream |
| frame_o | output | 1 | High while the sync pulse and the local word are being driven |

## Verification
Two chained instances are swept over walking-one words paired with their complement words, over all-zero and all-one words, over alternating words, and over a set of arithmetically generated pairs.

- The walking-one words separate a wrong bit order from an off-by-one shift.
- The complement pairs show whether the boundary between the upstream and downstream words falls on the right edge.
- The downstream tag input is driven from a parity function of the cycle number, so the pass-through delay on both instances is checked against exact edge counts.
- Separate scenarios cover:
  - a strobe arriving in the middle of a frame;
  - a restart during the shift phase;
  - chip select being raised partway through a frame;
  - a read/convert rise while chip select is high.

// File: rtl/ser_out_pkg.sv
package ser_out_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SHIFT = 2'd1,
    PH_PASS  = 2'd2
  } phase_e;
endpackage

// File: rtl/sos_ctrl.sv
module sos_ctrl
  import ser_out_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cs_n_i,
  input  logic   rc_i,
  output logic   start_o,
  output phase_e phase_o,
  output logic   sync_o,
  output logic   frame_o
);
  localparam int unsigned CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);

  logic             rc_q;
  logic [CNT_W-1:0] bit_cnt;
  phase_e           phase_q;

  // reset rc_q high so an idle-high rc_i does not fire a frame at reset release
  assign start_o = rc_i & ~rc_q & ~cs_n_i;
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rc_q    <= 1'b1;
      phase_q <= PH_IDLE;
      bit_cnt <= '0;
      sync_o  <= 1'b0;
      frame_o <= 1'b0;
    end else begin
      rc_q    <= rc_i;
      sync_o  <= start_o;
      frame_o <= ~cs_n_i & (start_o | (phase_q == PH_SHIFT));
      if (cs_n_i) begin
        phase_q <= PH_IDLE;
        bit_cnt <= '0;
      end else if (start_o) begin
        phase_q <= PH_SHIFT;
        bit_cnt <= '0;
      end else if (phase_q == PH_SHIFT) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) phase_q <= PH_PASS;
      end
    end
  end
endmodule

// File: rtl/sos_word_reg.sv
module sos_word_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] result_i,
  input  logic             result_valid_i,
  input  logic             load_i,
  input  logic             shift_i,
  output logic             msb_o
);
  logic [WIDTH-1:0] pend_q;
  logic [WIDTH-1:0] shreg_q;

  assign msb_o = shreg_q[WIDTH-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      shreg_q <= '0;
    end else begin
      if (result_valid_i) pend_q <= result_i;
      // load takes the word held before this edge
      if (load_i)       shreg_q <= pend_q;
      else if (shift_i) shreg_q <= {shreg_q[WIDTH-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/sos_tag_delay.sv
module sos_tag_delay #(
  parameter int unsigned STAGES = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tag_i,
  output logic tag_o
);
  logic [STAGES-1:0] pipe_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[0] <= 1'b0;
        else         pipe_q[0] <= tag_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[g] <= 1'b0;
        else         pipe_q[g] <= pipe_q[g-1];
      end
    end
  end

  assign tag_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ser_out_shifter.sv
module ser_out_shifter
  import ser_out_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             rc_i,
  input  logic             tag_i,
  input  logic [WIDTH-1:0] result_i,
  input  logic             result_valid_i,
  output logic             sync_o,
  output logic             data_o,
  output logic             frame_o
);
  // output register adds one stage, so the pipe is one short of the word
  localparam int unsigned TAG_STAGES = WIDTH - 1;

  logic   start;
  phase_e phase;
  logic   word_msb;
  logic   tag_dly;

  sos_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_n_i  (cs_n_i),
    .rc_i    (rc_i),
    .start_o (start),
    .phase_o (phase),
    .sync_o  (sync_o),
    .frame_o (frame_o)
  );

  sos_word_reg #(.WIDTH(WIDTH)) u_word (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .result_i       (result_i),
    .result_valid_i (result_valid_i),
    .load_i         (start),
    .shift_i        (phase == PH_SHIFT),
    .msb_o          (word_msb)
  );

  sos_tag_delay #(.STAGES(TAG_STAGES)) u_tag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tag_i  (tag_i),
    .tag_o  (tag_dly)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= 1'b0;
    end else if (cs_n_i || start) begin
      data_o <= 1'b0;
    end else begin
      unique case (phase)
        PH_SHIFT: data_o <= word_msb;
        PH_PASS:  data_o <= tag_dly;
        default:  data_o <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ser_out_shifter_chk.sv
module ser_out_shifter_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_n_i,
  input logic rc_i,
  input logic sync_o,
  input logic data_o,
  input logic frame_o
);
  localparam int unsigned LEN_W = $clog2(WIDTH + 2) + 1;

  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      len_q <= '0;
    else if (sync_o)  len_q <= LEN_W'(1);
    else if (frame_o) len_q <= len_q + 1'b1;
  end

  // R2
  sync_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);

  // R2
  sync_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> ($past(rc_i) && !$past(cs_n_i)));

  // R4
  frame_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_o) |-> sync_o);

  // R4
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(frame_o) && !$past(cs_n_i)) |-> (len_q == LEN_W'(WIDTH + 1)));

  // R8
  cs_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> (!sync_o && !data_o && !frame_o));
endmodule

bind ser_out_shifter ser_out_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_n_i  (cs_n_i),
  .rc_i    (rc_i),
  .sync_o  (sync_o),
  .data_o  (data_o),
  .frame_o (frame_o)
);

// File: tb/tb_ser_out_shifter.sv
module tb_ser_out_shifter;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0;
  logic rc = 1'b1;
  logic tag2 = 1'b0;
  logic [W-1:0] r1 = '0, r2 = '0;
  logic vld = 1'b0;
  logic sync1, data1, frame1, sync2, data2, frame2;

  int checks = 0, fails = 0, cyc = 0, e1 = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ser_out_shifter #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .rc_i(rc), .tag_i(data2),
    .result_i(r1), .result_valid_i(vld),
    .sync_o(sync1), .data_o(data1), .frame_o(frame1));

  ser_out_shifter #(.WIDTH(W)) u_dev2 (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .rc_i(rc), .tag_i(tag2),
    .result_i(r2), .result_valid_i(vld),
    .sync_o(sync2), .data_o(data2), .frame_o(frame2));

  // tag2 value present before rising edge c
  function automatic logic tagf(int c);
    logic [7:0] v = 8'(c);
    return ^(v & 8'hB5);
  endfunction

  task automatic step();
    @(posedge clk);
    cyc++;
    @(negedge clk);
    tag2 = tagf(cyc + 1);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load_words(logic [W-1:0] a, logic [W-1:0] b);
    r1 = a; r2 = b; vld = 1'b1;
    step();
    vld = 1'b0;
  endtask

  task automatic start_frame(string req);
    rc = 1'b0;
    step();
    rc = 1'b1;
    step();
    e1 = cyc;
    chk({req, " R2 sync at edge1"}, 32'(sync1), 32'd1);
    chk({req, " R4 frame at edge1"}, 32'(frame1), 32'd1);
  endtask

  // edges 2..40 after start_frame; optional strobe before edge sk
  task automatic read_frame(logic [W-1:0] a, logic [W-1:0] b, string req,
                            int sk, logic [W-1:0] na, logic [W-1:0] nb);
    logic [31:0] cap = '0;
    logic [W-1:0] p2 = '0, p2e = '0;
    logic [6:0] p1 = '0, p1e = '0;
    logic f17 = 1'b0, f18 = 1'b1, s2 = 1'b1;
    for (int k = 2; k <= 40; k++) begin
      if (k == sk) begin r1 = na; r2 = nb; vld = 1'b1; end
      step();
      vld = 1'b0;
      if (k == 2) s2 = sync1;
      if (k == 17) f17 = frame1;
      if (k == 18) f18 = frame1;
      if (k <= 33) cap = {cap[30:0], data1};
      if (k >= 18 && k <= 33) begin
        p2 = {p2[W-2:0], data2};
        p2e = {p2e[W-2:0], tagf(e1 + k - 1 - 15)};
      end
      if (k >= 34) begin
        p1 = {p1[5:0], data1};
        p1e = {p1e[5:0], tagf(e1 + k - 1 - 31)};
      end
    end
    chk({req, " R2 sync low at edge2"}, 32'(s2), 32'd0);
    chk({req, " R3 local word msb first"}, 32'(cap[31:16]), 32'(a));
    chk({req, " R6 chained 32 bits"}, cap, {a, b});
    chk({req, " R4 frame at edge17"}, 32'(f17), 32'd1);
    chk({req, " R4 frame at edge18"}, 32'(f18), 32'd0);
    chk({req, " R5 dev2 tag pass-through"}, 32'(p2), 32'(p2e));
    chk({req, " R5 dut tag pass-through"}, 32'(p1), 32'(p1e));
  endtask

  initial begin
    tag2 = tagf(1);
    #9;
    chk("R1 reset sync", 32'(sync1), 32'd0);
    chk("R1 reset data", 32'(data1), 32'd0);
    chk("R1 reset frame", 32'(frame1), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();
    chk("R1 no frame with rc high", {sync1, data1, frame1, sync2, frame2}, 32'd0);

    // R3 R6: walking ones against complements
    for (int i = 0; i < W; i++) begin
      load_words(W'(1) << i, ~(W'(1) << i));
      start_frame("walk");
      read_frame(W'(1) << i, ~(W'(1) << i), "walk", 0, '0, '0);
    end
    load_words('0, '1);        start_frame("zo"); read_frame('0, '1, "zo", 0, '0, '0);
    load_words('1, '0);        start_frame("oz"); read_frame('1, '0, "oz", 0, '0, '0);
    load_words('hAAAA, 'h5555); start_frame("alt"); read_frame('hAAAA, 'h5555, "alt", 0, '0, '0);
    for (int i = 1; i <= 8; i++) begin
      load_words(W'(i * 'h1357 + 'h0F0F), W'(i * 'h2B3D ^ 'h00FF));
      start_frame("arith");
      read_frame(W'(i * 'h1357 + 'h0F0F), W'(i * 'h2B3D ^ 'h00FF), "arith", 0, '0, '0);
    end

    // R7: strobe in mid-frame held for the next frame
    load_words('h1234, 'hABCD);
    start_frame("R7");
    read_frame('h1234, 'hABCD, "R7 current", 9, 'hC3A5, 'h0FF0);
    start_frame("R7");
    read_frame('hC3A5, 'h0FF0, "R7 next", 0, '0, '0);

    // R9: restart during shift with a new word held
    load_words('h8001, 'h7FFE);
    start_frame("R9");
    step(); step(); step();
    r1 = 'h5A5A; r2 = 'hE71C; vld = 1'b1; rc = 1'b0;
    step();
    vld = 1'b0;
    start_frame("R9 restart");
    read_frame('h5A5A, 'hE71C, "R9 restart", 0, '0, '0);

    // R8: chip select high cancels and blocks frames
    load_words('hFFFF, 'hFFFF);
    start_frame("R8");
    for (int i = 0; i < 4; i++) step();
    cs_n = 1'b1;
    step();
    chk("R8 outputs cleared", {sync1, data1, frame1}, 32'd0);
    rc = 1'b0; step(); rc = 1'b1; step();
    chk("R8 rc rise ignored sync", 32'(sync1), 32'd0);
    chk("R8 rc rise ignored frame", 32'(frame1), 32'd0);
    cs_n = 1'b0;
    step(); step(); step();
    chk("R8 no frame after cs low", {sync1, data1, frame1}, 32'd0);
    start_frame("R8 after");
    read_frame('hFFFF, 'hFFFF, "R8 after", 0, '0, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule